// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous-strobe DRAM alive by producing refresh cycles on the row strobe, the column strobe and the multiplexed address pins. A slow tick is derived inside the block by dividing the system clock. Each tick owes the memory one batch of refreshes. A batch covers a parameter-sized number of rows, so that normal accesses can run in the gaps between ticks.

One of three strobe orderings is chosen at elaboration. The first is row-strobe-only refresh, which drives a row counter kept inside the block onto the address pins. The second is column-before-row refresh, which needs no address. The third is hidden refresh, which takes the pins over from an access that has ended with the column strobe still low. In hidden mode the block pulses the row strobe while the column strobe stays low, and it never touches the data bus, so the read data stays valid.

The block sits beside the access sequencer, which reports that it is idle. A refresh that is owed starts only when the sequencer is idle. The refresh wins over a host request that arrives in the same cycle. Ticks that arrive while refreshes are still owed are kept in a small saturating debt counter, and the owed batches then run back to back. Control pins are plain levels. No data stream passes through the block, so it has no valid/ready interface.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, and whenever the block does not own the pins, `ras_n` and `cas_n` are 1, `addr_oe` is 0, `row_addr` is 0 and `bus_own` is 0.
- R2: An internal tick fires once every DIV = CLK_HZ/TICK_HZ cycles, counted from reset. Each tick adds one batch to the refresh debt.
- R3: Row-strobe-only mode runs this sequence for each row:
  - one cycle with both strobes high and the row driven (`addr_oe`=1);
  - T_RAS cycles with `ras_n`=0 and `cas_n`=1, with the row still driven;
  - T_PRE cycles with both strobes high and `addr_oe`=0.
- R4: In row-strobe-only mode `row_addr` starts at 0 after reset and rises by one after each refreshed row, wrapping modulo 2^ROW_W.
- R5: Column-before-row mode runs this sequence for each row, with `addr_oe` 0 throughout:
  - T_CR cycles with `cas_n`=0 and `ras_n`=1;
  - T_RAS cycles with both strobes low;
  - T_PRE cycles with both strobes high.
- R6: Hidden mode runs this sequence, with `addr_oe` 0 throughout:
  - one hand-off cycle with both strobes low;
  - for each row, T_PRE cycles with `ras_n`=1 and `cas_n`=0, then T_RAS cycles with both strobes low;
  - T_PRE cycles with both strobes high at the end.
- R7: Each batch refreshes exactly ROWS_PER_TICK rows.
- R8: A batch starts in the cycle after one in which the block is idle, the debt is non-zero and `acc_idle` is 1. It never starts while `acc_idle` is 0.
- R9: `host_gnt` = `host_req` AND `acc_idle` AND (block idle) AND (debt zero). A refresh that is owed therefore blocks a same-cycle host request.
- R10: The debt goes up on a tick and down when a batch starts; a tick and a start in the same cycle leave it unchanged. The debt saturates at 2^DEBT_W-1. Owed batches start back to back: a new batch starts one idle cycle after the previous one ends, as long as `acc_idle` is 1.
- R11: Every batch ends with `ras_n` high for T_PRE cycles before `bus_own` falls.
- R12: `bus_own` is 1 exactly in the cycles of a batch sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_idle | input | 1 | Access sequencer has no access running |
| host_req | input | 1 | Access sequencer asks to start a host access |
| host_gnt | output | 1 | Host access may start this cycle |
| bus_own | output | 1 | Refresh logic owns the strobes and address pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | Row address is being driven |
| row_addr | output | ROW_W | Refresh row address (row-strobe-only mode) |

## Verification
The bench builds all three modes at once and follows each cycle against a behavioural model. It goes after the following corner cases:
- A burst spread over rows. A design that miscounts rows per batch, or that omits the precharge gap between rows, would shift every later strobe edge.
- Refreshes blocked long enough for the debt to saturate. A counter that wrapped would lose batches; one that did not saturate would add extra batches. Either would show up in the batch count after the block is unblocked.
- A host request held during cycles with refresh owed. Granting it would break the priority rule.
- Row-counter wrap and the hidden hand-off cycle. An off-by-one in either would show up as a wrong address or a wrong strobe level.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    RF_RAS_ONLY = 2'd0,
    RF_CBR      = 2'd1,
    RF_HIDDEN   = 2'd2
  } rf_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HAND,
    ST_LEAD,
    ST_HI,
    ST_ACT,
    ST_PRE
  } rf_state_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic addr_oe;
  } rf_pins_t;
endpackage

// File: rtl/rfsh_tick_div.sv
module rfsh_tick_div #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt #(
  parameter int DEBT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pending
);
  localparam logic [DEBT_W-1:0] CAP = {DEBT_W{1'b1}};

  logic [DEBT_W-1:0] debt;

  assign pending = (debt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      debt <= '0;
    end else begin
      unique case ({tick, take})
        2'b10:   if (debt != CAP) debt <= debt + 1'b1;
        2'b01:   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter rf_mode_e MODE    = RF_CBR,
  parameter int       ROWS    = 1,
  parameter int       ROW_W   = 8,
  parameter int       T_CR    = 1,
  parameter int       T_RAS   = 2,
  parameter int       T_PRE   = 2,
  parameter int       LEN_W   = 2,
  parameter int       BURST_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_idle,
  input  logic             host_req,
  input  logic             pending,
  output logic             take,
  output logic             host_gnt,
  output logic             bus_own,
  output rf_pins_t         pins,
  output logic [ROW_W-1:0] addr
);
  localparam logic [LEN_W-1:0]   LEAD_LEN = (MODE == RF_RAS_ONLY) ? '0 : LEN_W'(T_CR - 1);
  localparam logic [LEN_W-1:0]   ACT_LEN  = LEN_W'(T_RAS - 1);
  localparam logic [LEN_W-1:0]   PRE_LEN  = LEN_W'(T_PRE - 1);
  localparam logic [BURST_W-1:0] BURST_LAST = BURST_W'(ROWS - 1);
  localparam bit IS_HIDDEN = (MODE == RF_HIDDEN);

  rf_state_e          state, st_nx;
  logic [LEN_W-1:0]   len_cnt, len_nx;
  logic [BURST_W-1:0] rows_left, rows_nx;
  logic [ROW_W-1:0]   row;
  logic               row_step;
  logic               idle, done;

  assign idle     = (state == ST_IDLE);
  assign done     = (len_cnt == '0);
  assign take     = idle && pending && acc_idle;
  assign host_gnt = idle && host_req && acc_idle && !pending;
  assign bus_own  = !idle;

  always_comb begin
    st_nx    = state;
    len_nx   = done ? len_cnt : len_cnt - 1'b1;
    rows_nx  = rows_left;
    row_step = 1'b0;
    unique case (state)
      ST_IDLE: if (take) begin
        rows_nx = BURST_LAST;
        if (IS_HIDDEN) begin
          st_nx  = ST_HAND;
          len_nx = '0;
        end else begin
          st_nx  = ST_LEAD;
          len_nx = LEAD_LEN;
        end
      end
      ST_HAND: begin
        st_nx  = ST_HI;
        len_nx = PRE_LEN;
      end
      ST_LEAD, ST_HI: if (done) begin
        st_nx  = ST_ACT;
        len_nx = ACT_LEN;
      end
      ST_ACT: if (done) begin
        row_step = (MODE == RF_RAS_ONLY);
        len_nx   = PRE_LEN;
        if (IS_HIDDEN && rows_left != '0) begin
          rows_nx = rows_left - 1'b1;
          st_nx   = ST_HI;
        end else begin
          st_nx   = ST_PRE;
        end
      end
      ST_PRE: if (done) begin
        if (!IS_HIDDEN && rows_left != '0) begin
          rows_nx = rows_left - 1'b1;
          st_nx   = ST_LEAD;
          len_nx  = LEAD_LEN;
        end else begin
          st_nx   = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      len_cnt   <= '0;
      rows_left <= '0;
      row       <= '0;
    end else begin
      state     <= st_nx;
      len_cnt   <= len_nx;
      rows_left <= rows_nx;
      if (row_step) row <= row + 1'b1;
    end
  end

  // Strobe ordering chosen by mode
  generate
    if (MODE == RF_RAS_ONLY) begin : g_ras_only
      assign pins.ras_n   = (state != ST_ACT);
      assign pins.cas_n   = 1'b1;
      assign pins.addr_oe = (state == ST_LEAD) || (state == ST_ACT);
      assign addr         = pins.addr_oe ? row : '0;
    end else if (MODE == RF_CBR) begin : g_cbr
      assign pins.ras_n   = (state != ST_ACT);
      assign pins.cas_n   = !((state == ST_LEAD) || (state == ST_ACT));
      assign pins.addr_oe = 1'b0;
      assign addr         = '0;
    end else begin : g_hidden
      assign pins.ras_n   = !((state == ST_HAND) || (state == ST_ACT));
      assign pins.cas_n   = !((state == ST_HAND) || (state == ST_HI) || (state == ST_ACT));
      assign pins.addr_oe = 1'b0;
      assign addr         = '0;
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import rfsh_pkg::*;
#(
  parameter rf_mode_e MODE          = RF_CBR,
  parameter int       CLK_HZ        = 50_000_000,
  parameter int       TICK_HZ       = 10_000,
  parameter int       ROWS_PER_TICK = 1,
  parameter int       ROW_W         = 8,
  parameter int       DEBT_W        = 2,
  parameter int       T_CR          = 1,
  parameter int       T_RAS         = 2,
  parameter int       T_PRE         = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_idle,
  input  logic             host_req,
  output logic             host_gnt,
  output logic             bus_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr
);
  localparam int DIV     = CLK_HZ / TICK_HZ;
  localparam int T_MAX   = (T_CR > T_RAS) ? ((T_CR > T_PRE) ? T_CR : T_PRE)
                                          : ((T_RAS > T_PRE) ? T_RAS : T_PRE);
  localparam int LEN_W   = $clog2(T_MAX + 1);
  localparam int BURST_W = $clog2(ROWS_PER_TICK + 1);

  logic     tick, take, pending;
  rf_pins_t pins;

  rfsh_tick_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rfsh_debt #(.DEBT_W(DEBT_W)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .take(take), .pending(pending)
  );

  rfsh_seq #(
    .MODE(MODE), .ROWS(ROWS_PER_TICK), .ROW_W(ROW_W), .T_CR(T_CR),
    .T_RAS(T_RAS), .T_PRE(T_PRE), .LEN_W(LEN_W), .BURST_W(BURST_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .acc_idle(acc_idle), .host_req(host_req),
    .pending(pending), .take(take), .host_gnt(host_gnt), .bus_own(bus_own),
    .pins(pins), .addr(row_addr)
  );

  assign ras_n   = pins.ras_n;
  assign cas_n   = pins.cas_n;
  assign addr_oe = pins.addr_oe;
endmodule

// File: rtl/rfsh_chk.sv
module rfsh_chk
  import rfsh_pkg::*;
#(
  parameter rf_mode_e MODE  = RF_CBR,
  parameter int       T_PRE = 2
) (
  input logic clk,
  input logic rst_n,
  input logic acc_idle,
  input logic host_gnt,
  input logic bus_own,
  input logic ras_n,
  input logic cas_n,
  input logic addr_oe
);
  logic [7:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                    hi_run <= '0;
    else if (bus_own && ras_n)     hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 1'b1;
    else                           hi_run <= '0;
  end

  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && cas_n && !addr_oe));

  p_ras_only_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == RF_RAS_ONLY) |-> cas_n);

  p_cas_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE == RF_CBR) && $fell(ras_n)) |-> (!cas_n && $past(!cas_n)));

  p_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE != RF_RAS_ONLY) |-> !addr_oe);

  p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE == RF_HIDDEN) && $rose(bus_own)) |-> (!ras_n && !cas_n));

  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(acc_idle));

  p_no_gnt_at_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> !$past(host_gnt));

  p_precharge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_own) |-> ($past(ras_n) && (int'(hi_run) >= T_PRE - 1)));
endmodule

bind dram_refresh_sched rfsh_chk #(.MODE(MODE), .T_PRE(T_PRE)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_idle(acc_idle), .host_gnt(host_gnt),
  .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe)
);

// File: tb/tb_rfsh_model.sv
module tb_rfsh_model #(
  parameter int MODE     = 1,
  parameter int DIV      = 100,
  parameter int ROWS     = 2,
  parameter int ROW_W    = 8,
  parameter int DEBT_MAX = 3,
  parameter int T_CR     = 2,
  parameter int T_RAS    = 3,
  parameter int T_PRE    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_idle,
  input  logic        host_req,
  output logic        e_ras_n,
  output logic        e_cas_n,
  output logic        e_oe,
  output logic [15:0] e_addr,
  output logic        e_own,
  output logic        e_gnt,
  output int          e_starts
);
  typedef struct packed {logic r; logic c; logic o; logic [15:0] a;} cyc_t;
  localparam cyc_t IDLE_C = '{r: 1'b1, c: 1'b1, o: 1'b0, a: 16'd0};

  cyc_t q[$];
  cyc_t cur = IDLE_C;
  int   tcnt = 0, debt = 0, row = 0, starts = 0;
  bit   midle = 1'b1;

  task automatic push(input logic r, input logic c, input logic o, input int a, input int n);
    for (int i = 0; i < n; i++) q.push_back('{r: r, c: c, o: o, a: 16'(a)});
  endtask

  task automatic build();
    if (MODE == 2) push(1'b0, 1'b0, 1'b0, 0, 1);
    for (int k = 0; k < ROWS; k++) begin
      if (MODE == 0) begin
        push(1'b1, 1'b1, 1'b1, row, 1);
        push(1'b0, 1'b1, 1'b1, row, T_RAS);
        row = (row + 1) % (1 << ROW_W);
        push(1'b1, 1'b1, 1'b0, 0, T_PRE);
      end else if (MODE == 1) begin
        push(1'b1, 1'b0, 1'b0, 0, T_CR);
        push(1'b0, 1'b0, 1'b0, 0, T_RAS);
        push(1'b1, 1'b1, 1'b0, 0, T_PRE);
      end else begin
        push(1'b1, 1'b0, 1'b0, 0, T_PRE);
        push(1'b0, 1'b0, 1'b0, 0, T_RAS);
      end
    end
    if (MODE == 2) push(1'b1, 1'b1, 1'b0, 0, T_PRE);
  endtask

  always @(posedge clk) begin
    bit tick, st;
    if (!rst_n) begin
      q.delete();
      tcnt = 0; debt = 0; row = 0; starts = 0;
      midle = 1'b1; cur = IDLE_C;
    end else begin
      tick = (tcnt == DIV - 1);
      st   = midle && (debt > 0) && acc_idle;
      tcnt = tick ? 0 : tcnt + 1;
      if (tick && !st && debt < DEBT_MAX) debt++;
      else if (st && !tick) debt--;
      if (q.size() > 0) begin
        cur = q.pop_front(); midle = 1'b0;
      end else if (st) begin
        build(); starts++;
        cur = q.pop_front(); midle = 1'b0;
      end else begin
        cur = IDLE_C; midle = 1'b1;
      end
    end
  end

  assign e_ras_n  = cur.r;
  assign e_cas_n  = cur.c;
  assign e_oe     = cur.o;
  assign e_addr   = cur.a;
  assign e_own    = !midle;
  assign e_gnt    = midle && host_req && acc_idle && (debt == 0);
  assign e_starts = starts;
endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
  import rfsh_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 1_000_000, TICK_HZ = 10_000, DIV = CLK_HZ / TICK_HZ;
  localparam int ROWS = 2, ROW_W = 8, DEBT_W = 2, T_CR = 2, T_RAS = 3, T_PRE = 2;

  logic clk = 1'b0, rst_n = 1'b0, acc_idle = 1'b0, host_req = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       d_gnt[3], d_own[3], d_ras[3], d_cas[3], d_oe[3];
  logic [7:0] d_addr[3];
  logic       e_gnt[3], e_own[3], e_ras[3], e_cas[3], e_oe[3];
  logic [15:0] e_addr[3];
  int         e_starts[3];

  int n_cmp = 0, n_bad = 0;
  bit run = 1'b0;
  int act_starts[3], hi_run[3];
  bit prev_own[3];

  for (genvar g = 0; g < 3; g++) begin : g_inst
    dram_refresh_sched #(
      .MODE(rf_mode_e'(g)), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ),
      .ROWS_PER_TICK(ROWS), .ROW_W(ROW_W), .DEBT_W(DEBT_W),
      .T_CR(T_CR), .T_RAS(T_RAS), .T_PRE(T_PRE)
    ) dut (
      .clk(clk), .rst_n(rst_n), .acc_idle(acc_idle), .host_req(host_req),
      .host_gnt(d_gnt[g]), .bus_own(d_own[g]), .ras_n(d_ras[g]),
      .cas_n(d_cas[g]), .addr_oe(d_oe[g]), .row_addr(d_addr[g])
    );
    tb_rfsh_model #(
      .MODE(g), .DIV(DIV), .ROWS(ROWS), .ROW_W(ROW_W), .DEBT_MAX((1 << DEBT_W) - 1),
      .T_CR(T_CR), .T_RAS(T_RAS), .T_PRE(T_PRE)
    ) mdl (
      .clk(clk), .rst_n(rst_n), .acc_idle(acc_idle), .host_req(host_req),
      .e_ras_n(e_ras[g]), .e_cas_n(e_cas[g]), .e_oe(e_oe[g]), .e_addr(e_addr[g]),
      .e_own(e_own[g]), .e_gnt(e_gnt[g]), .e_starts(e_starts[g])
    );
  end

  task automatic chk(input int m, input string tag, input string sig,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s mode%0d %s: actual %h expected %h at %0t", tag, m, sig, act, exp, $time);
    end
  endtask

  function automatic string seq_tag(input int m);
    return (m == 0) ? "R3" : (m == 1) ? "R5" : "R6";
  endfunction

  // Per-cycle comparison, a quarter period after the rising edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD / 4);
    if (run) begin
      for (int m = 0; m < 3; m++) begin
        if (!rst_n) begin
          chk(m, "R1", "ras_n",  16'(d_ras[m]), 16'd1);
          chk(m, "R1", "cas_n",  16'(d_cas[m]), 16'd1);
          chk(m, "R1", "addr_oe", 16'(d_oe[m]), 16'd0);
          chk(m, "R1", "bus_own", 16'(d_own[m]), 16'd0);
          chk(m, "R1", "row_addr", 16'(d_addr[m]), 16'd0);
        end else begin
          chk(m, seq_tag(m), "ras_n",   16'(d_ras[m]), 16'(e_ras[m]));
          chk(m, seq_tag(m), "cas_n",   16'(d_cas[m]), 16'(e_cas[m]));
          chk(m, "R7",  "addr_oe", 16'(d_oe[m]),  16'(e_oe[m]));
          chk(m, "R4",  "row_addr", 16'(d_addr[m]), e_addr[m]);
          chk(m, "R12", "bus_own", 16'(d_own[m]), 16'(e_own[m]));
          chk(m, "R9",  "host_gnt", 16'(d_gnt[m]), 16'(e_gnt[m]));
          if (prev_own[m] && !d_own[m])
            chk(m, "R11", "precharge_run_ok", 16'(hi_run[m] >= T_PRE), 16'd1);
          if (!prev_own[m] && d_own[m]) act_starts[m]++;
          hi_run[m] = (d_own[m] && d_ras[m]) ? hi_run[m] + 1 : 0;
          prev_own[m] = d_own[m];
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_starts(input string tag);
    for (int m = 0; m < 3; m++) chk(m, tag, "batch_count", 16'(act_starts[m]), 16'(e_starts[m]));
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin act_starts[m] = 0; hi_run[m] = 0; prev_own[m] = 0; end
    run = 1'b1;
    step(4);
    rst_n = 1'b1;
    // R2 R7: free running, accesses idle, host requests toggling
    for (int i = 0; i < 450; i++) begin
      acc_idle = 1'b1; host_req = (i % 3) != 0;
      step(1);
    end
    check_starts("R2");
    // R8: access sequencer busy in long stretches, host asking throughout
    for (int i = 0; i < 600; i++) begin
      acc_idle = (i % 27) >= 20; host_req = 1'b1;
      step(1);
    end
    check_starts("R8");
    // R10: blocked through five ticks (debt saturates), then released
    acc_idle = 1'b0; host_req = 1'b1;
    step(520);
    acc_idle = 1'b1;
    step(120);
    check_starts("R10");
    // R4 R9: mixed traffic long enough for the row counter to wrap
    for (int i = 0; i < 13000; i++) begin
      acc_idle = ($urandom % 10) < 7; host_req = $urandom % 2;
      step(1);
    end
    check_starts("R4");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule